// File: doc/BRIEF.md
# General-Purpose I/O Port with Filtered Pin Interrupts

This block controls one port of up to sixteen general-purpose pins through a small synchronous register bus. Software gives every pin one of four drive styles, updates the output data through a per-bit write guard, and reads back the pin levels as they arrive from the pads. The pad side gets a data value, an output enable and a weak pull-up request for each pin, and the block takes one pad input per pin.

Incoming pad levels cross into the clock domain through two flops. For each pin, software can place a noise filter after them. The filter samples on a shared strobe whose period is a power of two, from one cycle up to 32768 cycles. The strobe can also be paced by an external tick instead of every clock.

Each pin can raise a sticky interrupt flag on a low or falling condition, on a high or rising condition, or on both. It can look for a level or for an edge. All flags are ORed onto one interrupt line.

The register bus accepts one access in every cycle and never stalls. A write takes effect at the clock edge where `reg_we` is high. A read returns data in the same cycle, combinationally from `reg_addr`. The block therefore has no back-pressure and no valid/ready handshake.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every register reads 0. All pins are inputs, and `pad_oe`, `pad_pu` and `irq_o` are low.
- R2: The drive register at 0x00 holds 2 bits per pin at bits 2n+1:2n. The codes are:
  - 0: input. No drive and no pull-up.
  - 1: push-pull. `pad_oe`=1 and `pad_out` equals the data bit.
  - 2: open-drain. `pad_out`=0 and `pad_oe` is the inverse of the data bit. No pull-up.
  - 3: quasi-bidirectional. Like open-drain, but `pad_pu` equals the data bit.
- R3: A write to the output data register at 0x08 changes only the bits whose guard bit is 0 in the write guard register at 0x0C. Guarded bits keep their value. Both registers read back.
- R4: With filtering off, the pin value register at 0x10 shows the pad input two clock edges after the pad changes, and not after one edge.
- R5: A set bit in the input cut register at 0x04 makes that pin read as 0 at 0x10. That pin can then never set its interrupt flag.
- R6: The filter settings are as follows:
  - The filter enable register at 0x14 turns the filter on per pin.
  - Filter config bits 3:0 at 0x24 hold k, and the sample period is 2^k cycles.
  - A filtered pin changes only when two consecutive samples agree, so a pulse shorter than one period never appears.
- R7: The filter config has two more bits:
  - Bit 4 = 1 makes the sample prescaler advance only in cycles where `tick_alt` is high.
  - Bit 5 is stored and read back, and it has no effect on timing.
- R8: Each bit of the interrupt style register at 0x18 selects edge (0) or level (1) detection for its pin. In the enable register at 0x1C, bit n enables the low or falling condition and bit n+16 enables the high or rising condition.
- R9: The flag register at 0x20 works as follows:
  - Flags are sticky.
  - Writing 1 to a bit clears it, and the clear wins over a set in the same cycle.
  - A level condition that is still present sets the flag again on the next cycle.
  - An edge flag stays cleared until a new edge.
- R10: `irq_o` is high exactly when at least one flag is set.
- R11: Reads of offsets outside the map return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| pad_in | input | NPINS | Raw pad input levels |
| tick_alt | input | 1 | Alternative prescaler advance enable |
| pad_out | output | NPINS | Value driven to each pad |
| pad_oe | output | NPINS | Output enable per pad |
| pad_pu | output | NPINS | Weak pull-up request per pad |
| irq_o | output | 1 | OR of all interrupt flags |

## Verification
The bench builds the block with its defaults: sixteen pins and a 15-bit prescaler. With those defaults the enable register's split between its low half and its high half (bit n+16) is fully populated. The long filter period of 1024 cycles also fits within a run, so a held level can be shown to stay hidden for many cycles and then appear. Random drive codes, data and guard patterns across all sixteen pins cover every mode and mask combination. Directed sequences pin down the two-edge input latency, glitch rejection, pacing by the external tick, and the clear-versus-set priority on level flags.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    PM_IN    = 2'd0,
    PM_PUSH  = 2'd1,
    PM_OD    = 2'd2,
    PM_QUASI = 2'd3
  } pin_mode_e;

  localparam logic [5:0] A_MODE   = 6'h00;
  localparam logic [5:0] A_INOFF  = 6'h04;
  localparam logic [5:0] A_ODATA  = 6'h08;
  localparam logic [5:0] A_WMASK  = 6'h0C;
  localparam logic [5:0] A_PIN    = 6'h10;
  localparam logic [5:0] A_DBEN   = 6'h14;
  localparam logic [5:0] A_IMODE  = 6'h18;
  localparam logic [5:0] A_IRQEN  = 6'h1C;
  localparam logic [5:0] A_FLAGS  = 6'h20;
  localparam logic [5:0] A_DBCFG  = 6'h24;

  localparam int HI_OFS = 16;  // high/rising enables start here
  localparam int DBK_W  = 4;   // width of the period exponent
endpackage

// File: rtl/gpio_db_tick.sv
module gpio_db_tick #(
  parameter int CNT_W = 15
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alt_sel,
  input  logic                      tick_alt,
  input  logic [gpio_pkg::DBK_W-1:0] k,
  output logic                      strobe
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;
  logic             adv;

  assign adv    = alt_sel ? tick_alt : 1'b1;
  assign mask   = ~({CNT_W{1'b1}} << k);
  assign strobe = adv && ((cnt_q & mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (adv) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/gpio_in_path.sv
module gpio_in_path #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  input  logic [NPINS-1:0] dben,
  input  logic [NPINS-1:0] inoff,
  input  logic             strobe,
  output logic [NPINS-1:0] val
);
  logic [NPINS-1:0] s1_q, s2_q, last_q, filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pad_in;
      s2_q <= s1_q;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_filt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        last_q[i] <= 1'b0;
        filt_q[i] <= 1'b0;
      end else if (strobe) begin
        last_q[i] <= s2_q[i];
        if (s2_q[i] == last_q[i]) filt_q[i] <= s2_q[i];
      end
    end
    assign val[i] = ~inoff[i] & (dben[i] ? filt_q[i] : s2_q[i]);
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] val,
  input  logic [NPINS-1:0] inoff,
  input  logic [NPINS-1:0] level_sel,
  input  logic [NPINS-1:0] en_lo,
  input  logic [NPINS-1:0] en_hi,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] flags,
  output logic             irq
);
  logic [NPINS-1:0] prev_q, flag_q, cond;

  for (genvar i = 0; i < NPINS; i++) begin : g_det
    logic lvl_hit, edg_hit;
    assign lvl_hit = (~val[i] & en_lo[i]) | (val[i] & en_hi[i]);
    assign edg_hit = (prev_q[i] & ~val[i] & en_lo[i]) | (~prev_q[i] & val[i] & en_hi[i]);
    assign cond[i] = ~inoff[i] & (level_sel[i] ? lvl_hit : edg_hit);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        flag_q[i] <= 1'b0;
      end else begin
        prev_q[i] <= val[i];
        flag_q[i] <= (flag_q[i] | cond[i]) & ~clr[i];
      end
    end
  end

  assign flags = flag_q;
  assign irq   = |flag_q;
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int NPINS    = 16,
  parameter int DB_CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [5:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [NPINS-1:0] pad_in,
  input  logic             tick_alt,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pu,
  output logic             irq_o
);
  import gpio_pkg::*;

  localparam int MODE_W = 2 * NPINS;

  logic [MODE_W-1:0] mode_q;
  logic [NPINS-1:0]  inoff_q, odata_q, wmask_q, dben_q, imode_q, en_lo_q, en_hi_q;
  logic [5:0]        dbcfg_q;
  logic [NPINS-1:0]  val, flags, clr;
  logic              strobe;
  logic [NPINS-1:0]  wd;

  assign wd  = reg_wdata[NPINS-1:0];
  assign clr = (reg_we && reg_addr == A_FLAGS) ? wd : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      inoff_q <= '0;
      odata_q <= '0;
      wmask_q <= '0;
      dben_q  <= '0;
      imode_q <= '0;
      en_lo_q <= '0;
      en_hi_q <= '0;
      dbcfg_q <= '0;
    end else if (reg_we) begin
      unique case (reg_addr)
        A_MODE:  mode_q  <= reg_wdata[MODE_W-1:0];
        A_INOFF: inoff_q <= wd;
        A_ODATA: odata_q <= (odata_q & wmask_q) | (wd & ~wmask_q);
        A_WMASK: wmask_q <= wd;
        A_DBEN:  dben_q  <= wd;
        A_IMODE: imode_q <= wd;
        A_IRQEN: begin
          en_lo_q <= wd;
          en_hi_q <= reg_wdata[HI_OFS +: NPINS];
        end
        A_DBCFG: dbcfg_q <= reg_wdata[5:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_MODE:  reg_rdata[MODE_W-1:0] = mode_q;
      A_INOFF: reg_rdata[NPINS-1:0]  = inoff_q;
      A_ODATA: reg_rdata[NPINS-1:0]  = odata_q;
      A_WMASK: reg_rdata[NPINS-1:0]  = wmask_q;
      A_PIN:   reg_rdata[NPINS-1:0]  = val;
      A_DBEN:  reg_rdata[NPINS-1:0]  = dben_q;
      A_IMODE: reg_rdata[NPINS-1:0]  = imode_q;
      A_IRQEN: begin
        reg_rdata[NPINS-1:0]       = en_lo_q;
        reg_rdata[HI_OFS +: NPINS] = en_hi_q;
      end
      A_FLAGS: reg_rdata[NPINS-1:0]  = flags;
      A_DBCFG: reg_rdata[5:0]        = dbcfg_q;
      default: ;
    endcase
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pad
    logic d_out, d_oe, d_pu;
    always_comb begin
      d_out = 1'b0;
      d_oe  = 1'b0;
      d_pu  = 1'b0;
      case (mode_q[2*i +: 2])
        PM_PUSH:  begin d_oe = 1'b1; d_out = odata_q[i]; end
        PM_OD:    d_oe = ~odata_q[i];
        PM_QUASI: begin d_oe = ~odata_q[i]; d_pu = odata_q[i]; end
        default:  ;
      endcase
    end
    assign pad_out[i] = d_out;
    assign pad_oe[i]  = d_oe;
    assign pad_pu[i]  = d_pu;
  end

  gpio_db_tick #(.CNT_W(DB_CNT_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .alt_sel(dbcfg_q[4]), .tick_alt(tick_alt),
    .k(dbcfg_q[DBK_W-1:0]), .strobe(strobe)
  );

  gpio_in_path #(.NPINS(NPINS)) u_in (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .dben(dben_q),
    .inoff(inoff_q), .strobe(strobe), .val(val)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_irq (
    .clk(clk), .rst_n(rst_n), .val(val), .inoff(inoff_q), .level_sel(imode_q),
    .en_lo(en_lo_q), .en_hi(en_hi_q), .clr(clr), .flags(flags), .irq(irq_o)
  );
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int NPINS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [5:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [NPINS-1:0] odata,
  input logic [NPINS-1:0] wmask,
  input logic [1:0]       mode0,
  input logic             pad_oe0,
  input logic             inoff0,
  input logic [NPINS-1:0] flags,
  input logic             irq
);
  import gpio_pkg::*;

  // R3: guarded bits survive a data write
  a_r3_guard_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_ODATA) |=> ((odata & $past(wmask)) == ($past(odata) & $past(wmask))));

  // R3: unguarded bits take the written value
  a_r3_open_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_ODATA) |=>
      ((odata & ~$past(wmask)) == ($past(reg_wdata[NPINS-1:0]) & ~$past(wmask))));

  // R2: an input pin is never driven
  a_r2_input_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (mode0 == 2'd0) |-> !pad_oe0);

  // R5: a cut pin never sets its flag
  a_r5_cut_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> !$past(inoff0));

  // R9: clear wins over a set in the same cycle
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_FLAGS && reg_wdata[0]) |=> !flags[0]);

  // R10: the line rises only when a first flag appears
  a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(flags) == '0 && flags != '0));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .odata(odata_q), .wmask(wmask_q), .mode0(mode_q[1:0]),
  .pad_oe0(pad_oe[0]), .inoff0(inoff_q[0]), .flags(flags), .irq(irq_o)
);

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [5:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  pad_in = '0;
  logic          tick_alt = 1'b0;
  logic [N-1:0]  pad_out, pad_oe, pad_pu;
  logic          irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  gpio_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .tick_alt(tick_alt), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // expected pad triple {out, oe, pu} for a drive code and data bit
  function automatic logic [2:0] exp_pad(input logic [1:0] m, input logic d);
    case (m)
      2'd1:    return {d, 1'b1, 1'b0};
      2'd2:    return {1'b0, ~d, 1'b0};
      2'd3:    return {1'b0, ~d, d};
      default: return 3'b000;
    endcase
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r, m, d, od, mode, p, off;
    bit ok;
    void'($urandom(32'h1a2b3c4d));
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R1 reset state
    for (int a = 0; a <= 9; a++) begin
      rd(6'(a * 4), r);
      chk(r == 0, "R1 reset register", r, 0);
    end
    chk(pad_oe == 0 && pad_pu == 0 && irq_o == 0, "R1 reset pads", {pad_oe, pad_pu}, 0);

    // R2/R3 random drive codes, data and guards
    od = 0;
    for (int it = 0; it < 24; it++) begin
      mode = $urandom; m = $urandom & 32'hFFFF; d = $urandom;
      if (it == 0) m = 32'hFFFF;
      if (it == 1) m = 0;
      wr(gpio_pkg::A_MODE, mode);
      wr(gpio_pkg::A_WMASK, m);
      wr(gpio_pkg::A_ODATA, d);
      od = (od & m) | (d & ~m & 32'hFFFF);
      rd(gpio_pkg::A_ODATA, r);
      chk(r == od, "R3 guarded data write", r, od);
      rd(gpio_pkg::A_WMASK, r);
      chk(r == m, "R3 guard readback", r, m);
      ok = 1;
      for (int i = 0; i < N; i++)
        if ({pad_out[i], pad_oe[i], pad_pu[i]} != exp_pad(mode[2*i +: 2], od[i])) ok = 0;
      chk(ok, "R2 pad drive per code", {pad_out, pad_oe}, mode);
    end
    wr(gpio_pkg::A_MODE, 0);
    wr(gpio_pkg::A_WMASK, 0);
    chk(pad_oe == 0, "R2 all inputs undriven", pad_oe, 0);

    // R4 latency
    pad_in = 0; cyc(3);
    pad_in = 16'hFFFF;
    @(negedge clk); rd(gpio_pkg::A_PIN, r);
    chk(r == 0, "R4 not visible after one edge", r, 0);
    @(negedge clk); rd(gpio_pkg::A_PIN, r);
    chk(r == 32'hFFFF, "R4 visible after two edges", r, 32'hFFFF);

    // R4/R5 random levels with input cut
    for (int it = 0; it < 8; it++) begin
      p = $urandom & 32'hFFFF; off = $urandom & 32'hFFFF;
      wr(gpio_pkg::A_INOFF, off);
      pad_in = p[N-1:0];
      cyc(3);
      rd(gpio_pkg::A_PIN, r);
      chk(r == (p & ~off), "R5 R4 pin value with cut", r, p & ~off);
    end
    wr(gpio_pkg::A_INOFF, 0);

    // R6 glitch rejection, period 4
    pad_in = 0; cyc(3);
    wr(gpio_pkg::A_DBEN, 1);
    wr(gpio_pkg::A_DBCFG, 2);
    cyc(12);
    pad_in[0] = 1'b1; cyc(2); pad_in[0] = 1'b0;
    ok = 1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); rd(gpio_pkg::A_PIN, r);
      if (r[0]) ok = 0;
    end
    chk(ok, "R6 short pulse filtered", r, 0);
    pad_in[0] = 1'b1; pad_in[1] = 1'b1;
    cyc(3); rd(gpio_pkg::A_PIN, r);
    chk(r[1:0] == 2'b10, "R6 filtered pin lags, unfiltered passes", r, 2);
    cyc(11); rd(gpio_pkg::A_PIN, r);
    chk(r[1:0] == 2'b11, "R6 held level accepted", r, 3);

    // R6 long period 1024
    wr(gpio_pkg::A_DBCFG, 10);
    pad_in[0] = 1'b0;
    cyc(30); rd(gpio_pkg::A_PIN, r);
    chk(r[0] == 1'b1, "R6 long period still old", r, 1);
    cyc(2100); rd(gpio_pkg::A_PIN, r);
    chk(r[0] == 1'b0, "R6 long period settled", r, 0);

    // R7 bit 5 readback and external tick pacing
    wr(gpio_pkg::A_DBCFG, 32'h22);
    rd(gpio_pkg::A_DBCFG, r);
    chk(r == 32'h22, "R7 config readback", r, 32'h22);
    wr(gpio_pkg::A_DBCFG, 32'h10);
    tick_alt = 1'b0;
    pad_in[0] = 1'b1;
    cyc(20); rd(gpio_pkg::A_PIN, r);
    chk(r[0] == 1'b0, "R7 no tick no update", r, 0);
    tick_alt = 1'b1;
    cyc(5); rd(gpio_pkg::A_PIN, r);
    chk(r[0] == 1'b1, "R7 tick pacing update", r, 1);
    tick_alt = 1'b0;
    wr(gpio_pkg::A_DBEN, 0);
    wr(gpio_pkg::A_DBCFG, 0);

    // R8 R9 R10 interrupts
    pad_in = 0; cyc(4);
    wr(gpio_pkg::A_FLAGS, 32'hFFFF);
    rd(gpio_pkg::A_FLAGS, r);
    chk(r == 0 && irq_o == 0, "R10 no flags no irq", r, 0);

    wr(gpio_pkg::A_IRQEN, 32'h1 << 19);
    rd(gpio_pkg::A_IRQEN, r);
    chk(r == (32'h1 << 19), "R8 enable readback", r, 32'h1 << 19);
    pad_in[3] = 1'b1; cyc(4);
    rd(gpio_pkg::A_FLAGS, r);
    chk(r == 32'h8, "R8 rising edge flag", r, 8);
    chk(irq_o == 1'b1, "R10 irq with flag", irq_o, 1);
    pad_in[3] = 1'b0; cyc(4);
    wr(gpio_pkg::A_FLAGS, 32'h8);
    cyc(2); rd(gpio_pkg::A_FLAGS, r);
    chk(r == 0, "R9 edge flag stays cleared", r, 0);
    chk(irq_o == 1'b0, "R10 irq drops", irq_o, 0);

    wr(gpio_pkg::A_IRQEN, 32'h1 << 5);
    pad_in[5] = 1'b1; cyc(4);
    rd(gpio_pkg::A_FLAGS, r);
    chk(r == 0, "R8 rising ignored with falling enable", r, 0);
    pad_in[5] = 1'b0; cyc(4);
    rd(gpio_pkg::A_FLAGS, r);
    chk(r == 32'h20, "R8 falling edge flag", r, 32'h20);
    wr(gpio_pkg::A_FLAGS, 32'hFFFF);

    wr(gpio_pkg::A_IMODE, 32'h80);
    wr(gpio_pkg::A_IRQEN, 32'h1 << 23);
    pad_in[7] = 1'b1; cyc(4);
    rd(gpio_pkg::A_FLAGS, r);
    chk(r == 32'h80, "R8 high level flag", r, 32'h80);
    wr(gpio_pkg::A_FLAGS, 32'h80);
    rd(gpio_pkg::A_FLAGS, r);
    chk(r == 0, "R9 clear wins same cycle", r, 0);
    cyc(1); rd(gpio_pkg::A_FLAGS, r);
    chk(r == 32'h80, "R9 level sets again", r, 32'h80);
    pad_in[7] = 1'b0; cyc(3);
    wr(gpio_pkg::A_FLAGS, 32'h80);
    cyc(2); rd(gpio_pkg::A_FLAGS, r);
    chk(r == 0, "R9 gone level stays clear", r, 0);

    wr(gpio_pkg::A_INOFF, 32'h80);
    wr(gpio_pkg::A_IRQEN, 32'h80);
    wr(gpio_pkg::A_FLAGS, 32'hFFFF);
    cyc(4); rd(gpio_pkg::A_FLAGS, r);
    chk(r == 0 && irq_o == 0, "R5 cut pin raises nothing", r, 0);

    // R11 unmapped offsets
    rd(6'h28, r);
    chk(r == 0, "R11 unmapped read", r, 0);
    rd(6'h3C, r);
    chk(r == 0, "R11 unmapped read high", r, 0);

    finish_run();
  end
endmodule